// File: doc/BRIEF.md
# CSI Frame-Marker Packet Sequencer

This block watches a parallel video timing interface and emits the frame-start and frame-end short packets of a camera serial link. Its output goes to a four-lane, byte-wide D-PHY transmit interface. Vertical sync is high for the whole vertical blanking interval. When vsync rises, blanking begins and a frame-end marker is sent. When vsync falls, blanking ends and a frame-start marker is sent. Horizontal sync is active low. Each of its qualified falling edges is reported as a one-cycle line-start strobe.

Both sync inputs pass through an agreement filter. A new level counts only when it is sampled on two consecutive clocks. This removes the one-clock hsync pulse that appears when vsync releases a clock before hsync asserts, and it removes any other single-clock spike.

Each marker goes out in its own burst on all four data lanes: LP-11 hold, LP-00 bridge, sync byte, one payload cycle, trail, then back to LP-11. The packet is four bytes: data identifier, frame number low byte, frame number high byte, ECC. Byte k is placed on lane k. A request that arrives during a burst waits and is launched when the burst ends. The controller states are:

- ST_STOP: idle, LP-11.
- ST_HOLD11: timed LP-11.
- ST_BRIDGE00: timed LP-00.
- ST_SYNC: sync byte.
- ST_PAYLOAD: packet bytes.
- ST_TRAIL: timed trail.

Its transitions are:

- launch: ST_STOP to ST_HOLD11 when a request is pending.
- hold_done: ST_HOLD11 to ST_BRIDGE00 when the LP-11 count expires.
- bridge_done: ST_BRIDGE00 to ST_SYNC when the LP-00 count expires.
- sync_sent: ST_SYNC to ST_PAYLOAD after one cycle.
- payload_sent: ST_PAYLOAD to ST_TRAIL after one cycle.
- trail_done: ST_TRAIL to ST_STOP when the trail count expires.

Top module: `csi_fmark_tx`

## Requirements
- R1: During and right after reset, every lane shows LP-11 (dl_lp_p = dl_lp_n = 4'hF), dl_hs_en = 0, dl_hs_byte = 0 and line_start = 0.
- R2: A level on vsync_in or hsync_n_in that is sampled on only one clock edge is ignored. It produces no line_start pulse and no burst.
- R3: line_start is a single-cycle pulse. It is high in the cycle that starts 3 clock edges after hsync_n_in falls, provided the low level is sampled on at least two consecutive edges.
- R4: A qualified vsync rise requests a frame-end packet with identifier 8'h01. A qualified vsync fall requests a frame-start packet with identifier 8'h00.
- R5: A burst is LP-11 for max(cfg_lp11_cyc,1) cycles, then LP-00 for max(cfg_lp00_cyc,1) cycles. Then dl_hs_en = 4'hF with byte 8'hB8 on every lane (bit 0 is sent first, so the wire order is 00011101). Then one payload cycle with lane k carrying packet byte k: identifier, frame number [7:0], frame number [15:8], ECC.
- R6: From idle, the sync cycle begins 5 + max(cfg_lp11_cyc,1) + max(cfg_lp00_cyc,1) clock edges after the vsync change that requested it.
- R7: ECC bit j is the XOR of the header bits H[23:0] = {frame number, identifier} selected by mask Mj. The masks are M0=24'hF12CB7, M1=24'hF2555B, M2=24'h749A6D, M3=24'hB8E38E, M4=24'hDF03F0 and M5=24'hEFFC00. ECC bits 7:6 are 0.
- R8: After the payload cycle, lane k sends for max(cfg_trail_cyc,1) cycles a byte whose bits all equal the inverse of bit 7 of its payload byte. The lanes then return to LP-11 with dl_hs_en = 0.
- R9: The frame number resets to 0 and advances when a frame-start burst is launched. The frame-start packet carries the new value and a frame-end packet carries the current value. After FNUM_MAX the next value is 1.
- R10: A request arriving during a burst is held and launched after the burst ends. If both kinds are pending, the one requested first is sent first.
- R11: dl_lp_p always equals dl_lp_n. dl_hs_en is either all zeros or all ones, and whenever it is set the low-power lines are 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync_in | input | 1 | Vertical sync, high during blanking |
| hsync_n_in | input | 1 | Horizontal sync, active low |
| cfg_lp11_cyc | input | CFG_W | LP-11 hold length (0 acts as 1) |
| cfg_lp00_cyc | input | CFG_W | LP-00 bridge length (0 acts as 1) |
| cfg_trail_cyc | input | CFG_W | Trail length (0 acts as 1) |
| line_start | output | 1 | One-cycle qualified line strobe |
| dl_lp_p | output | 4 | Low-power positive line per lane |
| dl_lp_n | output | 4 | Low-power negative line per lane |
| dl_hs_en | output | 4 | High-speed drive enable per lane |
| dl_hs_byte | output | 32 | High-speed byte per lane, lane k at [8k+7:8k] |

## Verification
The line strobe is due 3 edges after a held hsync fall. The sync byte of a burst started from idle is due 5 + hold + bridge edges after the vsync change. The payload follows 1 edge later, and the trail lasts exactly its configured length. The driver stamps each expected packet with the cycle counter value at the moment it changes vsync, and it stores the due sync cycle for bursts launched from idle. The monitor samples on falling clock edges and compares the observed sync cycle, LP-00 run length, payload bytes and trail length against the oldest queued item. Bursts that were delayed as pending are checked for order and content but not for their start cycle.

// File: rtl/csi_fm_pkg.sv
package csi_fm_pkg;
    localparam int          NLANES    = 4;
    localparam int          PKT_BYTES = 4;
    localparam logic [7:0]  SYNC_BYTE = 8'hB8;
    localparam logic [7:0]  DT_FSTART = 8'h00;
    localparam logic [7:0]  DT_FEND   = 8'h01;
    localparam int          HDR_W     = 24;
    localparam int          PAR_BITS  = 6;
    localparam logic [PAR_BITS*HDR_W-1:0] PAR_MASKS = {
        24'hEFFC00, 24'hDF03F0, 24'hB8E38E,
        24'h749A6D, 24'hF2555B, 24'hF12CB7
    };

    typedef enum logic [2:0] {
        ST_STOP,
        ST_HOLD11,
        ST_BRIDGE00,
        ST_SYNC,
        ST_PAYLOAD,
        ST_TRAIL
    } fm_state_e;
endpackage

// File: rtl/fm_deglitch.sv
module fm_deglitch #(
    parameter int           W        = 2,
    parameter logic [W-1:0] IDLE_LVL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] chg
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s0_q, s1_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s0_q   <= IDLE_LVL[i];
                s1_q   <= IDLE_LVL[i];
                lvl[i] <= IDLE_LVL[i];
                chg[i] <= 1'b0;
            end else begin
                s0_q   <= raw[i];
                s1_q   <= s0_q;
                chg[i] <= 1'b0;
                // new level accepted only once two samples agree
                if ((s0_q == s1_q) && (s1_q != lvl[i])) begin
                    lvl[i] <= s1_q;
                    chg[i] <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fm_ecc.sv
module fm_ecc
    import csi_fm_pkg::*;
(
    input  logic [HDR_W-1:0] hdr,
    output logic [7:0]       ecc
);
    for (genvar j = 0; j < 8; j++) begin : g_par
        if (j < PAR_BITS) begin : g_on
            assign ecc[j] = ^(hdr & PAR_MASKS[j*HDR_W +: HDR_W]);
        end else begin : g_off
            assign ecc[j] = 1'b0;
        end
    end
endmodule

// File: rtl/fm_burst_fsm.sv
module fm_burst_fsm
    import csi_fm_pkg::*;
#(
    parameter int          CFG_W    = 8,
    parameter logic [15:0] FNUM_MAX = 16'hFFFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_fe,
    input  logic                req_fs,
    input  logic [CFG_W-1:0]    cfg_lp11,
    input  logic [CFG_W-1:0]    cfg_lp00,
    input  logic [CFG_W-1:0]    cfg_trail,
    output logic [NLANES-1:0]   lp_p,
    output logic [NLANES-1:0]   lp_n,
    output logic [NLANES-1:0]   hs_en,
    output logic [NLANES*8-1:0] hs_byte
);
    localparam logic [CFG_W-1:0] ONE = CFG_W'(1);

    fm_state_e state_q, state_d;
    logic [CFG_W-1:0]       cnt_q;
    logic                   pend_fe_q, pend_fs_q, fe_first_q;
    logic [15:0]            fnum_q;
    logic [PKT_BYTES*8-1:0] pkt_q;

    logic [CFG_W-1:0] lp11_eff, lp00_eff, trail_eff;
    logic             launch, pick_fe, fe_keep, fs_keep, cnt_last;
    logic [15:0]      fnum_inc, fnum_use;
    logic [HDR_W-1:0] hdr_nxt;
    logic [7:0]       ecc_nxt;

    assign lp11_eff  = (cfg_lp11  == '0) ? ONE : cfg_lp11;
    assign lp00_eff  = (cfg_lp00  == '0) ? ONE : cfg_lp00;
    assign trail_eff = (cfg_trail == '0) ? ONE : cfg_trail;
    assign cnt_last  = (cnt_q == ONE);

    assign launch   = (state_q == ST_STOP) && (pend_fe_q || pend_fs_q);
    assign pick_fe  = pend_fe_q && (!pend_fs_q || fe_first_q);
    assign fe_keep  = pend_fe_q && !(launch && pick_fe);
    assign fs_keep  = pend_fs_q && !(launch && !pick_fe);
    assign fnum_inc = (fnum_q == FNUM_MAX) ? 16'd1 : fnum_q + 16'd1;
    assign fnum_use = pick_fe ? fnum_q : fnum_inc;
    assign hdr_nxt  = {fnum_use, (pick_fe ? DT_FEND : DT_FSTART)};

    fm_ecc u_ecc (.hdr(hdr_nxt), .ecc(ecc_nxt));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP:     if (launch)   state_d = ST_HOLD11;
            ST_HOLD11:   if (cnt_last) state_d = ST_BRIDGE00;
            ST_BRIDGE00: if (cnt_last) state_d = ST_SYNC;
            ST_SYNC:                   state_d = ST_PAYLOAD;
            ST_PAYLOAD:                state_d = ST_TRAIL;
            ST_TRAIL:    if (cnt_last) state_d = ST_STOP;
            default:                   state_d = ST_STOP;
        endcase
    end

    // interval counter, pending requests, frame number, packet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            pend_fe_q  <= 1'b0;
            pend_fs_q  <= 1'b0;
            fe_first_q <= 1'b0;
            fnum_q     <= '0;
            pkt_q      <= '0;
        end else begin
            unique case (state_q)
                ST_STOP:     if (launch) cnt_q <= lp11_eff;
                ST_HOLD11:   cnt_q <= cnt_last ? lp00_eff : cnt_q - ONE;
                ST_BRIDGE00: cnt_q <= cnt_q - ONE;
                ST_PAYLOAD:  cnt_q <= trail_eff;
                ST_TRAIL:    cnt_q <= cnt_q - ONE;
                default:     cnt_q <= cnt_q;
            endcase
            pend_fe_q <= fe_keep || req_fe;
            pend_fs_q <= fs_keep || req_fs;
            if (req_fe && !fe_keep) fe_first_q <= !fs_keep;
            if (req_fs && !fs_keep) fe_first_q <= fe_keep;
            if (launch) begin
                fnum_q <= fnum_use;
                pkt_q  <= {ecc_nxt, hdr_nxt};
            end
        end
    end

    // line-state outputs
    always_comb begin
        lp_p  = '1;
        lp_n  = '1;
        hs_en = '0;
        unique case (state_q)
            ST_BRIDGE00: begin
                lp_p = '0;
                lp_n = '0;
            end
            ST_SYNC, ST_PAYLOAD, ST_TRAIL: begin
                lp_p  = '0;
                lp_n  = '0;
                hs_en = '1;
            end
            default: ;
        endcase
    end

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        always_comb begin
            unique case (state_q)
                ST_SYNC:    hs_byte[l*8 +: 8] = SYNC_BYTE;
                ST_PAYLOAD: hs_byte[l*8 +: 8] = pkt_q[l*8 +: 8];
                ST_TRAIL:   hs_byte[l*8 +: 8] = {8{~pkt_q[l*8+7]}};
                default:    hs_byte[l*8 +: 8] = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/csi_fmark_tx.sv
module csi_fmark_tx
    import csi_fm_pkg::*;
#(
    parameter int          CFG_W    = 8,
    parameter logic [15:0] FNUM_MAX = 16'hFFFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vsync_in,
    input  logic                hsync_n_in,
    input  logic [CFG_W-1:0]    cfg_lp11_cyc,
    input  logic [CFG_W-1:0]    cfg_lp00_cyc,
    input  logic [CFG_W-1:0]    cfg_trail_cyc,
    output logic                line_start,
    output logic [NLANES-1:0]   dl_lp_p,
    output logic [NLANES-1:0]   dl_lp_n,
    output logic [NLANES-1:0]   dl_hs_en,
    output logic [NLANES*8-1:0] dl_hs_byte
);
    logic [1:0] sy_lvl, sy_chg;
    logic       fe_req, fs_req;

    // bit 1 hsync (idle high), bit 0 vsync (idle low)
    fm_deglitch #(.W(2), .IDLE_LVL(2'b10)) u_dg (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({hsync_n_in, vsync_in}),
        .lvl  (sy_lvl),
        .chg  (sy_chg)
    );

    assign fe_req     = sy_chg[0] &  sy_lvl[0];
    assign fs_req     = sy_chg[0] & ~sy_lvl[0];
    assign line_start = sy_chg[1] & ~sy_lvl[1];

    fm_burst_fsm #(.CFG_W(CFG_W), .FNUM_MAX(FNUM_MAX)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_fe   (fe_req),
        .req_fs   (fs_req),
        .cfg_lp11 (cfg_lp11_cyc),
        .cfg_lp00 (cfg_lp00_cyc),
        .cfg_trail(cfg_trail_cyc),
        .lp_p     (dl_lp_p),
        .lp_n     (dl_lp_n),
        .hs_en    (dl_hs_en),
        .hs_byte  (dl_hs_byte)
    );
endmodule

// File: rtl/fm_chk.sv
module fm_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        line_start,
    input logic [3:0]  lp_p,
    input logic [3:0]  lp_n,
    input logic [3:0]  hs_en,
    input logic [31:0] hs_byte
);
    // R11
    lp_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lp_p == lp_n);
    // R11
    hs_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hs_en) |-> (hs_en == 4'hF && lp_p == 4'h0));
    // R5
    sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en[0]) |-> (hs_byte == {4{8'hB8}}));
    // R5
    bridge_before_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en[0]) |-> ($past(lp_p) == 4'h0));
    // R8
    stop_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_en[0]) |-> (lp_p == 4'hF));
    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !line_start);
endmodule

bind csi_fmark_tx fm_chk u_fm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_start(line_start),
    .lp_p      (dl_lp_p),
    .lp_n      (dl_lp_n),
    .hs_en     (dl_hs_en),
    .hs_byte   (dl_hs_byte)
);

// File: tb/tb_csi_fmark_tx.sv
module tb_csi_fmark_tx;
    localparam logic [15:0] FMAX = 16'd3;

    typedef struct packed {
        logic [7:0]  di;
        logic [15:0] fn;
        logic [31:0] due;
        logic [7:0]  l00;
        logic [7:0]  tr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vsync = 1'b0;
    logic        hsync_n = 1'b1;
    logic [7:0]  c11 = 8'd3, c00 = 8'd2, ctr = 8'd2;
    logic        line_start;
    logic [3:0]  lp_p, lp_n, hs_en;
    logic [31:0] hs_byte;

    int   cyc = 0;
    int   n_chk = 0, n_fail = 0;
    int   ls_cnt = 0, ls_cyc = 0, bursts = 0;
    bit   mon_busy = 0;
    logic [15:0] tb_fnum = 16'd0;
    exp_t exp_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    csi_fmark_tx #(.CFG_W(8), .FNUM_MAX(FMAX)) dut (
        .clk(clk), .rst_n(rst_n), .vsync_in(vsync), .hsync_n_in(hsync_n),
        .cfg_lp11_cyc(c11), .cfg_lp00_cyc(c00), .cfg_trail_cyc(ctr),
        .line_start(line_start), .dl_lp_p(lp_p), .dl_lp_n(lp_n),
        .dl_hs_en(hs_en), .dl_hs_byte(hs_byte)
    );

    function automatic int eff(input logic [7:0] v);
        return (v == 8'd0) ? 1 : int'(v);
    endfunction

    function automatic logic [7:0] ref_ecc(input logic [23:0] d);
        logic [7:0] e;
        e = 8'h00;
        e[0] = d[0]^d[1]^d[2]^d[4]^d[5]^d[7]^d[10]^d[11]^d[13]^d[16]^d[20]^d[21]^d[22]^d[23];
        e[1] = d[0]^d[1]^d[3]^d[4]^d[6]^d[8]^d[10]^d[12]^d[14]^d[17]^d[20]^d[21]^d[22]^d[23];
        e[2] = d[0]^d[2]^d[3]^d[5]^d[6]^d[9]^d[11]^d[12]^d[15]^d[18]^d[20]^d[21]^d[22];
        e[3] = d[1]^d[2]^d[3]^d[7]^d[8]^d[9]^d[13]^d[14]^d[15]^d[19]^d[20]^d[21]^d[23];
        e[4] = d[4]^d[5]^d[6]^d[7]^d[8]^d[9]^d[16]^d[17]^d[18]^d[19]^d[20]^d[22]^d[23];
        e[5] = d[10]^d[11]^d[12]^d[13]^d[14]^d[15]^d[16]^d[17]^d[18]^d[19]^d[21]^d[22]^d[23];
        return e;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // driver: change vsync and queue the expected packet
    task automatic vs_set(input logic v, input bit timed);
        exp_t e;
        @(negedge clk);
        vsync = v;
        if (!v) tb_fnum = (tb_fnum == FMAX) ? 16'd1 : tb_fnum + 16'd1;
        e.di  = v ? 8'h01 : 8'h00;
        e.fn  = tb_fnum;
        e.due = timed ? 32'(cyc + 5 + eff(c11) + eff(c00)) : 32'd0;
        e.l00 = 8'(eff(c00));
        e.tr  = 8'(eff(ctr));
        exp_q.push_back(e);
    endtask

    task automatic hs_low(input int n);
        @(negedge clk);
        hsync_n = 1'b0;
        repeat (n) @(negedge clk);
        hsync_n = 1'b1;
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
        while (exp_q.size() != 0 || mon_busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // line strobe monitor
    always @(negedge clk) if (rst_n && line_start) begin
        ls_cnt++;
        ls_cyc = cyc;
    end

    // burst monitor / scoreboard
    initial begin
        int l00_run;
        l00_run = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) continue;
            if (hs_en == 4'h0) begin
                l00_run = (lp_p == 4'h0) ? l00_run + 1 : 0;
            end else begin
                exp_t e;
                int tr;
                logic [31:0] pay;
                mon_busy = 1;
                bursts++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected burst", 32'(bursts), 32'd0);
                    e = '0;
                end else e = exp_q.pop_front();
                chk(hs_byte == {4{8'hB8}}, "R5 sync byte", hs_byte, {4{8'hB8}});
                chk(lp_n == 4'h0, "R11 lp_n during hs", 32'(lp_n), 32'd0);
                chk(l00_run == int'(e.l00), "R5 LP-00 length", 32'(l00_run), 32'(e.l00));
                if (e.due != 0) chk(cyc == int'(e.due), "R6 sync cycle", 32'(cyc), e.due);
                @(negedge clk);
                pay = {ref_ecc({e.fn, e.di}), e.fn[15:8], e.fn[7:0], e.di};
                chk(hs_byte[7:0] == e.di, "R4 R10 identifier", 32'(hs_byte[7:0]), 32'(e.di));
                chk(hs_byte[23:8] == e.fn, "R9 frame number", 32'(hs_byte[23:8]), 32'(e.fn));
                chk(hs_byte[31:24] == pay[31:24], "R7 ecc", 32'(hs_byte[31:24]), 32'(pay[31:24]));
                tr = 0;
                @(negedge clk);
                while (hs_en != 4'h0) begin
                    for (int k = 0; k < 4; k++)
                        chk(hs_byte[k*8 +: 8] == {8{~pay[k*8+7]}}, "R8 trail byte",
                            32'(hs_byte[k*8 +: 8]), 32'({8{~pay[k*8+7]}}));
                    tr++;
                    @(negedge clk);
                end
                chk(tr == int'(e.tr), "R8 trail length", 32'(tr), 32'(e.tr));
                chk(lp_p == 4'hF && lp_n == 4'hF, "R8 back to LP-11", {lp_p, lp_n}, 32'hFF);
                l00_run = 0;
                mon_busy = 0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end

    initial begin
        int n0, b0, s0;
        repeat (4) @(negedge clk);
        // R1 reset state while in reset
        chk(lp_p == 4'hF && lp_n == 4'hF, "R1 LP-11 in reset", {lp_p, lp_n}, 32'hFF);
        chk(hs_en == 4'h0 && hs_byte == 32'h0, "R1 hs idle in reset", hs_byte, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(line_start == 1'b0 && lp_p == 4'hF, "R1 after reset", {line_start, lp_p}, 32'hF);

        // A: frame end (R4, R6)
        vs_set(1'b1, 1'b1);
        drain();
        // B: frame start with one-clock hsync glitch a clock later (R2)
        s0 = ls_cnt;
        vs_set(1'b0, 1'b1);
        hs_low(1);
        drain();
        chk(ls_cnt == s0, "R2 hsync glitch ignored", 32'(ls_cnt), 32'(s0));
        // C: held hsync fall gives one strobe 3 edges later (R3)
        s0 = ls_cnt;
        @(negedge clk);
        n0 = cyc;
        hsync_n = 1'b0;
        repeat (4) @(negedge clk);
        hsync_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(ls_cnt == s0 + 1, "R3 one strobe", 32'(ls_cnt), 32'(s0 + 1));
        chk(ls_cyc == n0 + 3, "R3 strobe cycle", 32'(ls_cyc), 32'(n0 + 3));
        // D: one-clock vsync spike produces no burst (R2)
        b0 = bursts;
        @(negedge clk);
        vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
        repeat (30) @(negedge clk);
        chk(bursts == b0, "R2 vsync glitch ignored", 32'(bursts), 32'(b0));
        // E: zero config clamps to one (R5, R8)
        c11 = 8'd0; c00 = 8'd0; ctr = 8'd0;
        vs_set(1'b1, 1'b1);
        drain();
        vs_set(1'b0, 1'b1);
        drain();
        // F: requests during a long burst, order kept (R10)
        c11 = 8'd20; c00 = 8'd3; ctr = 8'd4;
        vs_set(1'b1, 1'b1);
        repeat (3) @(negedge clk);
        vs_set(1'b0, 1'b0);
        repeat (3) @(negedge clk);
        vs_set(1'b1, 1'b0);
        drain();
        // G: frame number wraps past FMAX back to 1 (R9)
        c11 = 8'd2; c00 = 8'd1; ctr = 8'd1;
        vs_set(1'b0, 1'b1);
        drain();
        chk(tb_fnum == 16'd1, "R9 wrap model", 32'(tb_fnum), 32'd1);
        chk(exp_q.size() == 0, "R10 all packets sent", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule